// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Attribute Writes

This block controls 32 general-purpose pins, grouped as two banks of sixteen. Each pin carries eight configuration and data attributes: drive value, drive enable, open-drain mode, drive inversion, pull-up request, pull-down request, input enable and input inversion. Each attribute lives in its own per-bank register.

A register write never overwrites a register. The lower half of the write data names pins whose attribute becomes 1. The upper half names pins whose attribute becomes 0. Pins named in neither half keep their state. Software can therefore change one pin without reading the register first, and two agents sharing a bank cannot undo each other's updates.

On the pad side, the block turns the attribute state into drive value, drive enable and pull requests for each pin. It also passes the incoming pin levels through a two-flop synchroniser. A read-back register returns those synchronised levels after optional inversion, masked by input enable.

The register bus is a plain control interface. A write completes in the cycle that `bus_wr` is high. A read strobe `bus_rd` returns `bus_rdata` on the following cycle. There is no back-pressure: the block accepts every access.

Top module: `gpio_setclr_bank`

## Requirements
- R1: After reset every attribute of every pin is 0. `pad_out`, `pad_oe`, `pad_pu`, `pad_pd` and `bus_rdata` are all 0.
- R2: In a write, a 1 in data bit n (n = 0..15) sets the addressed attribute of pin n of the addressed bank to 1.
- R3: In a write, a 1 in data bit n+16 clears that pin's attribute to 0. Pins whose set and clear bits are both 0 keep their value.
- R4: When the set bit and the clear bit of the same pin are both 1 in one write, the attribute ends at 0.
- R5: Address bit 7 selects the bank. 0 selects pins 0..15, and 1 (offset 0x80) selects pins 16..31 (bank pin n is chip pin 16+n). Address bits 6..0 select the register within the bank.
- R6: The register offsets within a bank are:

  | Offset | Register |
  |---|---|
  | 0x00 | drive value |
  | 0x04 | drive enable |
  | 0x08 | open-drain |
  | 0x0C | drive invert |
  | 0x18 | pull-up |
  | 0x1C | pull-down |
  | 0x20 | input enable |
  | 0x24 | input invert |
  | 0x30 | read-back (read-only) |

- R7: A read with `bus_rd` high returns data on `bus_rdata` in the next cycle. The data holds the 16-bit register state in bits 15..0, and bits 31..16 read 0.
- R8: For a pin not in open-drain mode, `pad_out` equals drive value XOR drive invert, and `pad_oe` equals drive enable.
- R9: For a pin in open-drain mode, `pad_out` is 0. `pad_oe` is 1 only when drive enable is 1 and drive value XOR drive invert is 0.
- R10: `pad_pu` and `pad_pd` equal the pin's pull-up and pull-down attributes.
- R11: Read-back bit n equals the pin input after two register stages, XOR input invert, AND input enable. A level applied to `pad_in` before clock edge k is captured by the second stage at edge k+1.
- R12: A write to the read-back offset or to an unmapped offset changes nothing. A read from an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address: bit 7 bank, bits 6..0 register offset |
| bus_wdata | input | 32 | Write data: set mask in low half, clear mask in high half |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 32 | Raw pin input levels |
| pad_out | output | 32 | Value driven to each pin |
| pad_oe | output | 32 | Drive enable for each pin |
| pad_pu | output | 32 | Pull-up request for each pin |
| pad_pd | output | 32 | Pull-down request for each pin |

## Verification
The bench targets the following corner cases:

- A write that sets and clears the same pin. A design that lets the set win would leave the attribute at 1.
- Writes that touch only the upper half. A design that treated the data as a plain store would wipe the untouched pins.
- Open-drain pins whose effective value is 1. These must release the pad, so a design that drives them would show `pad_oe` high with `pad_out` at 0.
- The input latency, checked by reading right after an input change. A design that has one stage too many or too few returns the new value too late or too early.
- Accesses to the read-back and unmapped offsets. A decoder that aliases these offsets would corrupt an attribute register or return stale data.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int NUM_ATTR = 8;

  typedef enum logic [2:0] {
    ATTR_DRV_VAL  = 3'd0,
    ATTR_DRV_EN   = 3'd1,
    ATTR_OPEN_DRN = 3'd2,
    ATTR_DRV_INV  = 3'd3,
    ATTR_PULL_UP  = 3'd4,
    ATTR_PULL_DN  = 3'd5,
    ATTR_IN_EN    = 3'd6,
    ATTR_IN_INV   = 3'd7
  } attr_e;

  localparam logic [6:0] OFF_READBACK = 7'h30;

  typedef struct packed {
    logic  hit;
    attr_e idx;
  } attr_sel_t;

  function automatic attr_sel_t attr_lookup(input logic [6:0] off);
    attr_sel_t s;
    s.hit = 1'b1;
    s.idx = ATTR_DRV_VAL;
    case (off)
      7'h00:   s.idx = ATTR_DRV_VAL;
      7'h04:   s.idx = ATTR_DRV_EN;
      7'h08:   s.idx = ATTR_OPEN_DRN;
      7'h0C:   s.idx = ATTR_DRV_INV;
      7'h18:   s.idx = ATTR_PULL_UP;
      7'h1C:   s.idx = ATTR_PULL_DN;
      7'h20:   s.idx = ATTR_IN_EN;
      7'h24:   s.idx = ATTR_IN_INV;
      default: s.hit = 1'b0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_setclr_reg.sv
module gpio_setclr_reg #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2*W-1:0] wdata,
  output logic [W-1:0]   q
);

  logic [W-1:0] set_m;
  logic [W-1:0] clr_m;

  assign set_m = wdata[W-1:0];
  assign clr_m = wdata[2*W-1:W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (wr_en) q <= (q | set_m) & ~clr_m;
  end

  p_set_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(set_m & ~clr_m)) == $past(set_m & ~clr_m)));

  p_clear_wins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & $past(clr_m)) == '0));

  p_untouched_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((q & ~$past(set_m | clr_m)) == ($past(q) & ~$past(set_m | clr_m))));

  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q));

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] sync_out
);

  logic [N-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= raw_in;
      sync_out <= stage1;
    end
  end

endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive #(
  parameter int N = 32
) (
  input  logic [N-1:0] drv_val,
  input  logic [N-1:0] drv_inv,
  input  logic [N-1:0] drv_en,
  input  logic [N-1:0] open_drn,
  output logic [N-1:0] pad_out,
  output logic [N-1:0] pad_oe
);

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_pin
      logic eff;
      assign eff        = drv_val[i] ^ drv_inv[i];
      assign pad_out[i] = open_drn[i] ? 1'b0 : eff;
      assign pad_oe[i]  = drv_en[i] & (open_drn[i] ? ~eff : 1'b1);
    end
  endgenerate

endmodule

// File: rtl/gpio_setclr_bank.sv
module gpio_setclr_bank
  import gpio_pkg::*;
#(
  parameter int BANK_PINS = 16,
  parameter int NBANKS    = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [7+$clog2(NBANKS)-1:0]   bus_addr,
  input  logic [2*BANK_PINS-1:0]        bus_wdata,
  output logic [2*BANK_PINS-1:0]        bus_rdata,
  input  logic [NBANKS*BANK_PINS-1:0]   pad_in,
  output logic [NBANKS*BANK_PINS-1:0]   pad_out,
  output logic [NBANKS*BANK_PINS-1:0]   pad_oe,
  output logic [NBANKS*BANK_PINS-1:0]   pad_pu,
  output logic [NBANKS*BANK_PINS-1:0]   pad_pd
);

  localparam int W      = BANK_PINS;
  localparam int BUS_W  = 2 * W;
  localparam int NPINS  = NBANKS * W;
  localparam int BSEL_W = $clog2(NBANKS);
  localparam int ADDR_W = 7 + BSEL_W;

  logic [BSEL_W-1:0] bank_sel;
  logic [6:0]        reg_off;
  attr_sel_t         dec;
  logic              is_rb;

  assign bank_sel = bus_addr[ADDR_W-1:7];
  assign reg_off  = bus_addr[6:0];
  assign dec      = attr_lookup(reg_off);
  assign is_rb    = (reg_off == OFF_READBACK);

  logic [W-1:0] attr_q [NBANKS][NUM_ATTR];

  genvar b, a;
  generate
    for (b = 0; b < NBANKS; b++) begin : g_bank
      for (a = 0; a < NUM_ATTR; a++) begin : g_attr
        logic we;
        assign we = bus_wr && dec.hit && (bank_sel == BSEL_W'(b)) &&
                    (dec.idx == attr_e'(a));
        gpio_setclr_reg #(.W(W)) u_reg (
          .clk   (clk),
          .rst_n (rst_n),
          .wr_en (we),
          .wdata (bus_wdata),
          .q     (attr_q[b][a])
        );
      end
    end
  endgenerate

  logic [NPINS-1:0] v_drv_val, v_drv_en, v_open_drn, v_drv_inv;
  logic [NPINS-1:0] v_in_en, v_in_inv;

  always_comb begin
    for (int k = 0; k < NBANKS; k++) begin
      v_drv_val [k*W +: W] = attr_q[k][ATTR_DRV_VAL];
      v_drv_en  [k*W +: W] = attr_q[k][ATTR_DRV_EN];
      v_open_drn[k*W +: W] = attr_q[k][ATTR_OPEN_DRN];
      v_drv_inv [k*W +: W] = attr_q[k][ATTR_DRV_INV];
      pad_pu    [k*W +: W] = attr_q[k][ATTR_PULL_UP];
      pad_pd    [k*W +: W] = attr_q[k][ATTR_PULL_DN];
      v_in_en   [k*W +: W] = attr_q[k][ATTR_IN_EN];
      v_in_inv  [k*W +: W] = attr_q[k][ATTR_IN_INV];
    end
  end

  gpio_pad_drive #(.N(NPINS)) u_drive (
    .drv_val  (v_drv_val),
    .drv_inv  (v_drv_inv),
    .drv_en   (v_drv_en),
    .open_drn (v_open_drn),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe)
  );

  logic [NPINS-1:0] in_sync;
  logic [NPINS-1:0] readback;

  gpio_in_sync #(.N(NPINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (pad_in),
    .sync_out (in_sync)
  );

  assign readback = (in_sync ^ v_in_inv) & v_in_en;

  logic [BUS_W-1:0] rd_next;

  always_comb begin
    rd_next = '0;
    if (is_rb) begin
      rd_next[W-1:0] = readback[bank_sel*W +: W];
    end else if (dec.hit) begin
      rd_next[W-1:0] = attr_q[bank_sel][dec.idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  p_rdata_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_rdata[BUS_W-1:W] == '0));

  p_unmapped_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !dec.hit && !is_rb) |=> (bus_rdata == '0));

  p_od_never_drives_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((v_open_drn & pad_oe & pad_out) == '0));

  p_od_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((v_open_drn & pad_oe & (v_drv_val ^ v_drv_inv)) == '0));

endmodule

// File: tb/tb_gpio_setclr_bank.sv
`timescale 1ns/1ps
module tb_gpio_setclr_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;

  always #2 clk = ~clk;

  gpio_setclr_bank dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  // Reference model: attribute order 0 value,1 enable,2 od,3 drive inv,
  // 4 pull-up,5 pull-down,6 input enable,7 input invert
  int unsigned m_attr [2][8];
  int unsigned m_s1 = 0, m_s2 = 0, m_rdata = 0;

  function automatic int off_to_attr(input int off);
    case (off)
      'h00: return 0; 'h04: return 1; 'h08: return 2; 'h0C: return 3;
      'h18: return 4; 'h1C: return 5; 'h20: return 6; 'h24: return 7;
      default: return -1;
    endcase
  endfunction

  function automatic int unsigned rb_bank(input int bk);
    int unsigned pins = (m_s2 >> (16*bk)) & 'hFFFF;
    return (pins ^ m_attr[bk][7]) & m_attr[bk][6];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_attr[i, j]) m_attr[i][j] = 0;
      m_s1 = 0; m_s2 = 0; m_rdata = 0;
    end else begin
      int bk, off, ai;
      bk  = bus_addr[7];
      off = bus_addr[6:0];
      ai  = off_to_attr(off);
      if (bus_rd) begin
        if (off == 'h30)  m_rdata = rb_bank(bk);
        else if (ai >= 0) m_rdata = m_attr[bk][ai];
        else              m_rdata = 0;
      end
      if (bus_wr && ai >= 0)
        m_attr[bk][ai] = (m_attr[bk][ai] | bus_wdata[15:0]) & ~{16'h0, bus_wdata[31:16]} & 'hFFFF;
      m_s2 = m_s1;
      m_s1 = pad_in;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [31:0] eo, eoe, epu, epd;
      for (int p = 0; p < 32; p++) begin
        int bk, bt;
        bit eff, od;
        bk = p / 16; bt = p % 16;
        eff = ((m_attr[bk][0] ^ m_attr[bk][3]) >> bt) & 1;
        od  = (m_attr[bk][2] >> bt) & 1;
        eo[p]  = od ? 1'b0 : eff;
        eoe[p] = ((m_attr[bk][1] >> bt) & 1) && (!od || !eff);
        epu[p] = (m_attr[bk][4] >> bt) & 1;
        epd[p] = (m_attr[bk][5] >> bt) & 1;
      end
      check("R8/R9 pad_out", pad_out, eo);
      check("R8/R9 pad_oe", pad_oe, eoe);
      check("R10 pad_pu", pad_pu, epu);
      check("R10 pad_pd", pad_pd, epd);
      check("R7 rdata model", bus_rdata, m_rdata);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    check(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 pad_out reset", pad_out, 32'h0);
    check("R1 pad_oe reset", pad_oe, 32'h0);
    check("R1 rdata reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    rd_check("R1 value reg reset", 8'h00, 32'h0);

    wr(8'h00, 32'h0000_0005);
    rd_check("R2 set bits", 8'h00, 32'h0000_0005);
    wr(8'h00, 32'h0001_0000);
    rd_check("R3 clear bit0 keeps bit2", 8'h00, 32'h0000_0004);
    wr(8'h00, 32'h0002_0002);
    rd_check("R4 clear wins", 8'h00, 32'h0000_0004);
    wr(8'h84, 32'h0000_FFFF);
    rd_check("R7 upper half zero", 8'h84, 32'h0000_FFFF);
    wr(8'h84, 32'hFFFF_0000);
    wr(8'h80, 32'h0000_8000);
    rd_check("R5 high bank", 8'h80, 32'h0000_8000);
    rd_check("R5 low bank untouched", 8'h00, 32'h0000_0004);

    wr(8'h04, 32'h0000_000F);
    check("R8 pad_oe push-pull", pad_oe, 32'h0000_000F);
    check("R8 pad_out push-pull", pad_out, 32'h8000_0004);
    wr(8'h0C, 32'h0000_0001);
    check("R8 drive invert", pad_out, 32'h8000_0005);
    rd_check("R6 drive invert offset", 8'h0C, 32'h0000_0001);
    wr(8'h08, 32'h0000_000C);
    check("R9 od oe", pad_oe, 32'h0000_000B);
    check("R9 od out", pad_out, 32'h8000_0001);

    wr(8'h18, 32'h0000_00F0);
    wr(8'h9C, 32'h0000_0001);
    check("R10 pull-up", pad_pu, 32'h0000_00F0);
    check("R10 pull-down high bank", pad_pd, 32'h0001_0000);
    rd_check("R6 pull-down offset", 8'h9C, 32'h0000_0001);

    wr(8'h20, 32'h0000_00FF);
    wr(8'h24, 32'h0000_0001);
    @(negedge clk) pad_in = 32'h0001_00A5;
    rd_check("R11 latency old value", 8'h30, 32'h0000_0001);
    repeat (2) @(negedge clk);
    rd_check("R11 readback", 8'h30, 32'h0000_00A4);
    rd_check("R11 input disabled bank", 8'hB0, 32'h0000_0000);

    wr(8'h30, 32'h0000_FFFF);
    wr(8'h10, 32'h0000_FFFF);
    wr(8'h40, 32'h0000_FFFF);
    rd_check("R12 value reg unchanged", 8'h00, 32'h0000_0004);
    rd_check("R12 input enable unchanged", 8'h20, 32'h0000_00FF);
    rd_check("R12 unmapped read", 8'h10, 32'h0000_0000);
    check("R12 pads unchanged", pad_out, 32'h8000_0001);

    @(negedge clk) pad_in = 32'h0000_005A;
    repeat (3) @(negedge clk);
    rd_check("R11 readback new pattern", 8'h30, 32'h0000_005B);

    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule